// File: doc/BRIEF.md
# Core Register File with Mode-Selected Constants

This block is the working register set of a small 16-bit processor core: sixteen 16-bit entries, of which four carry fixed roles. Entry 0 is the program counter, entry 1 the stack pointer, entry 2 the status word, and entry 3 a constant source with no storage behind it. Entries 4 to 15 are plain general-purpose registers. Two independent combinational read ports each take a register index and a 2-bit source-mode code. One general write port, a program-counter advance strobe and a masked status-flag update port change the state on the rising clock edge.

When a read port selects entry 3, or selects entry 2 in any mode other than direct, it returns a fixed value picked by the mode code instead of stored data. Instruction streams can therefore use the common small constants without fetching an extra immediate word. The general write port treats the program counter, stack pointer and status word like any other register. This lets arithmetic results land directly in them. Both pointers stay word aligned.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first write, every entry reads 0 on both ports, and `pc_out` and `sr_out` are 0.
- R2: A write with `wr_en` high to an entry 4..15 stores `wr_data`, and both read ports return it from the cycle after the clock edge onward.
- R3: Entry 3 read through either port returns a constant set by the mode code: 2'b00 gives 0x0000, 2'b01 gives 0x0001, 2'b10 gives 0x0002, 2'b11 gives 0xFFFF.
- R4: A general write to entry 3 has no effect: entry 3 keeps returning the R3 constants, and no other entry changes.
- R5: Entry 2 read with mode 2'b00 returns the status word. Mode 2'b01 returns 0x0000, mode 2'b10 returns 0x0004 and mode 2'b11 returns 0x0008.
- R6: For entries 0, 1 and 4..15 the mode code has no effect, and the stored value is returned.
- R7: A general write may target entries 0, 1 and 2. For entries 0 and 1, bit 0 of the stored value is forced to 0. Entry 2 stores all 16 bits unchanged.
- R8: With `pc_inc` high, the program counter grows by 2 modulo 65536. If a general write to entry 0 happens in the same cycle, the written value (with bit 0 cleared) is stored instead.
- R9: With `flag_we` high, the status bits where `flag_mask` is 1 take the `flag_val` bits, and the other bits keep their value. A general write to entry 2 in the same cycle takes priority over this update.
- R10: The two read ports work independently and at the same time, each with its own index and mode. `pc_out` and `sr_out` always show entries 0 and 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_mode | input | 2 | Read port A source-mode code |
| rd_a_data | output | 16 | Read port A data (combinational) |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_mode | input | 2 | Read port B source-mode code |
| rd_b_data | output | 16 | Read port B data (combinational) |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write register index |
| wr_data | input | 16 | General write data |
| pc_inc | input | 1 | Program counter advance strobe |
| flag_we | input | 1 | Status flag update enable |
| flag_mask | input | 16 | Status bits to update |
| flag_val | input | 16 | New values for the masked status bits |
| pc_out | output | 16 | Current program counter |
| sr_out | output | 16 | Current status word |

## Verification
The read ports are combinational. A constant or stored value is due in the same cycle as the index and mode that select it. General writes, counter advances and flag updates take effect at the next rising edge, and become visible on the reads and on `pc_out`/`sr_out` in the cycle after that edge. The bench changes inputs one nanosecond after each rising edge. Its behavioural model applies the state update at the same rising edge as the design. All four outputs are compared against the model at the falling edge, once the combinational paths have settled on the new inputs. The collision cases, where a write and a counter advance or flag update hit the same entry in one cycle, are driven in one cycle and checked in the next.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;

   typedef enum logic [1:0] {
      SRC_DIRECT  = 2'b00,
      SRC_OFFSET  = 2'b01,
      SRC_DEREF   = 2'b10,
      SRC_POSTINC = 2'b11
   } src_mode_e;

   // Entry roles; the read and write paths depend on these positions
   localparam int unsigned ROLE_PC = 0;
   localparam int unsigned ROLE_SP = 1;
   localparam int unsigned ROLE_SR = 2;
   localparam int unsigned ROLE_CG = 3;

   typedef enum logic [2:0] {
      SLOT_PC,
      SLOT_SP,
      SLOT_SR,
      SLOT_CONST,
      SLOT_GP
   } slot_kind_e;

   function automatic slot_kind_e slot_kind(input int unsigned i);
      if (i == ROLE_PC)      return SLOT_PC;
      else if (i == ROLE_SP) return SLOT_SP;
      else if (i == ROLE_SR) return SLOT_SR;
      else if (i == ROLE_CG) return SLOT_CONST;
      else                   return SLOT_GP;
   endfunction

endpackage

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
module rf_wr_decode #(
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   output logic [NUM_REGS-1:0] hit
);
   import rf_pkg::*;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_hit
      if (slot_kind(i) == SLOT_CONST) begin : g_drop
         // writes to the constant source are dropped here
         assign hit[i] = 1'b0;
      end else begin : g_cmp
         assign hit[i] = wr_en && (wr_idx == IDX_W'(i));
      end
   end

endmodule

// File: rtl/rf_bank.sv
`timescale 1ns/1ps
module rf_bank #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned PC_STEP   = 2,
   parameter int unsigned ALIGN_LSB = 1
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic [NUM_REGS-1:0]              hit,
   input  logic [DATA_W-1:0]                wr_data,
   input  logic                             pc_inc,
   input  logic                             flag_we,
   input  logic [DATA_W-1:0]                flag_mask,
   input  logic [DATA_W-1:0]                flag_val,
   output logic [NUM_REGS-1:0][DATA_W-1:0]  regs
);
   import rf_pkg::*;

   localparam logic [DATA_W-1:0] LOW_BITS   = DATA_W'((1 << ALIGN_LSB) - 1);
   localparam logic [DATA_W-1:0] ALIGN_KEEP = ~LOW_BITS;
   localparam logic [DATA_W-1:0] STEP       = DATA_W'(PC_STEP);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      if (slot_kind(i) == SLOT_CONST) begin : g_const
         logic unused_const_hit;
         assign unused_const_hit = hit[i];
         assign regs[i] = '0;
      end else if (slot_kind(i) == SLOT_PC) begin : g_pc
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= '0;
            else if (hit[i])    q <= wr_data & ALIGN_KEEP;
            else if (pc_inc)    q <= (q + STEP) & ALIGN_KEEP;
         end
         assign regs[i] = q;
      end else if (slot_kind(i) == SLOT_SP) begin : g_sp
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= '0;
            else if (hit[i])    q <= wr_data & ALIGN_KEEP;
         end
         assign regs[i] = q;
      end else if (slot_kind(i) == SLOT_SR) begin : g_sr
         logic [DATA_W-1:0] q;
         logic [DATA_W-1:0] merged;
         always_comb merged = (q & ~flag_mask) | (flag_val & flag_mask);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= '0;
            else if (hit[i])    q <= wr_data;
            else if (flag_we)   q <= merged;
         end
         assign regs[i] = q;
      end else begin : g_gp
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         q <= '0;
            else if (hit[i])    q <= wr_data;
         end
         assign regs[i] = q;
      end
   end

endmodule

// File: rtl/rf_src_sel.sv
`timescale 1ns/1ps
module rf_src_sel #(
   parameter int unsigned DATA_W   = 16,
   parameter int unsigned NUM_REGS = 16,
   localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
   input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
   input  logic [IDX_W-1:0]                idx,
   input  logic [1:0]                      mode,
   output logic [DATA_W-1:0]               data
);
   import rf_pkg::*;

   localparam logic [DATA_W-1:0] K_ZERO = '0;
   localparam logic [DATA_W-1:0] K_ONE  = DATA_W'(1);
   localparam logic [DATA_W-1:0] K_TWO  = DATA_W'(2);
   localparam logic [DATA_W-1:0] K_FOUR = DATA_W'(4);
   localparam logic [DATA_W-1:0] K_EIGHT= DATA_W'(8);
   localparam logic [DATA_W-1:0] K_ALL  = '1;

   src_mode_e m;
   logic [DATA_W-1:0] stored;

   always_comb begin
      m      = src_mode_e'(mode);
      stored = regs[idx];
      if (idx == IDX_W'(ROLE_CG)) begin
         unique case (m)
            SRC_DIRECT:  data = K_ZERO;
            SRC_OFFSET:  data = K_ONE;
            SRC_DEREF:   data = K_TWO;
            SRC_POSTINC: data = K_ALL;
            default:     data = K_ZERO;
         endcase
      end else if (idx == IDX_W'(ROLE_SR)) begin
         unique case (m)
            SRC_DIRECT:  data = stored;
            SRC_OFFSET:  data = K_ZERO;
            SRC_DEREF:   data = K_FOUR;
            SRC_POSTINC: data = K_EIGHT;
            default:     data = stored;
         endcase
      end else begin
         data = stored;
      end
   end

endmodule

// File: rtl/cpu_regfile.sv
`timescale 1ns/1ps
module cpu_regfile #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned PC_STEP   = 2,
   parameter int unsigned ALIGN_LSB = 1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [1:0]        rd_a_mode,
   output logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   input  logic [1:0]        rd_b_mode,
   output logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pc_inc,
   input  logic              flag_we,
   input  logic [DATA_W-1:0] flag_mask,
   input  logic [DATA_W-1:0] flag_val,
   output logic [DATA_W-1:0] pc_out,
   output logic [DATA_W-1:0] sr_out
);
   import rf_pkg::*;

   localparam int unsigned N_PORTS = 2;

   // elaboration-time parameter checks
   if (NUM_REGS < 4) begin : g_bad_depth
      $error("cpu_regfile: NUM_REGS must cover the four role entries");
   end
   if ((1 << IDX_W) != NUM_REGS) begin : g_bad_pow2
      $error("cpu_regfile: NUM_REGS must be a power of two");
   end
   if (DATA_W < 4) begin : g_bad_width
      $error("cpu_regfile: DATA_W too narrow for the constant 8");
   end
   if (ALIGN_LSB >= DATA_W) begin : g_bad_align
      $error("cpu_regfile: ALIGN_LSB must be below DATA_W");
   end

   logic [NUM_REGS-1:0]              hit;
   logic [NUM_REGS-1:0][DATA_W-1:0]  regs;

   rf_wr_decode #(.NUM_REGS(NUM_REGS)) u_dec (
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .hit    (hit)
   );

   rf_bank #(
      .DATA_W    (DATA_W),
      .NUM_REGS  (NUM_REGS),
      .PC_STEP   (PC_STEP),
      .ALIGN_LSB (ALIGN_LSB)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .hit       (hit),
      .wr_data   (wr_data),
      .pc_inc    (pc_inc),
      .flag_we   (flag_we),
      .flag_mask (flag_mask),
      .flag_val  (flag_val),
      .regs      (regs)
   );

   logic [N_PORTS-1:0][IDX_W-1:0]  p_idx;
   logic [N_PORTS-1:0][1:0]        p_mode;
   logic [N_PORTS-1:0][DATA_W-1:0] p_data;

   assign p_idx  = {rd_b_idx,  rd_a_idx};
   assign p_mode = {rd_b_mode, rd_a_mode};

   for (genvar p = 0; p < N_PORTS; p++) begin : g_port
      rf_src_sel #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_sel (
         .regs (regs),
         .idx  (p_idx[p]),
         .mode (p_mode[p]),
         .data (p_data[p])
      );
   end

   assign rd_a_data = p_data[0];
   assign rd_b_data = p_data[1];
   assign pc_out    = regs[ROLE_PC];
   assign sr_out    = regs[ROLE_SR];

endmodule

// File: rtl/cpu_regfile_chk.sv
`timescale 1ns/1ps
module cpu_regfile_chk #(
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned NUM_REGS  = 16,
   parameter int unsigned PC_STEP   = 2,
   parameter int unsigned ALIGN_LSB = 1,
   localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  rd_a_idx,
   input  logic [1:0]        rd_a_mode,
   input  logic [DATA_W-1:0] rd_a_data,
   input  logic [IDX_W-1:0]  rd_b_idx,
   input  logic [1:0]        rd_b_mode,
   input  logic [DATA_W-1:0] rd_b_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              pc_inc,
   input  logic              flag_we,
   input  logic [DATA_W-1:0] flag_mask,
   input  logic [DATA_W-1:0] flag_val,
   input  logic [DATA_W-1:0] pc_out,
   input  logic [DATA_W-1:0] sr_out
);
   localparam logic [DATA_W-1:0] LOW  = DATA_W'((1 << ALIGN_LSB) - 1);
   localparam logic [IDX_W-1:0]  I_PC = IDX_W'(0);
   localparam logic [IDX_W-1:0]  I_SR = IDX_W'(2);
   localparam logic [IDX_W-1:0]  I_CG = IDX_W'(3);

   // R3
   cg_port_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == I_CG) |->
         rd_a_data == ((rd_a_mode == 2'b11) ? {DATA_W{1'b1}} : DATA_W'(rd_a_mode)));

   // R3
   cg_port_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_b_idx == I_CG) |->
         rd_b_data == ((rd_b_mode == 2'b11) ? {DATA_W{1'b1}} : DATA_W'(rd_b_mode)));

   // R5
   sr_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == I_SR && rd_a_mode == 2'b00) |-> rd_a_data == sr_out);

   // R5
   sr_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_a_idx == I_SR && rd_a_mode == 2'b10) |-> rd_a_data == DATA_W'(4));

   // R7
   pc_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_out & LOW) == '0);

   // R8
   pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_inc && !(wr_en && wr_idx == I_PC)) |=>
         pc_out == $past(pc_out) + DATA_W'(PC_STEP));

   // R8
   pc_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == I_PC) |=> pc_out == ($past(wr_data) & ~LOW));

   // R9
   flag_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we && !(wr_en && wr_idx == I_SR)) |=>
         ((sr_out & $past(flag_mask)) == ($past(flag_val) & $past(flag_mask))) &&
         ((sr_out & ~$past(flag_mask)) == ($past(sr_out) & ~$past(flag_mask))));

   // R9
   sr_write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_idx == I_SR) |=> sr_out == $past(wr_data));

endmodule

bind cpu_regfile cpu_regfile_chk #(
   .DATA_W    (DATA_W),
   .NUM_REGS  (NUM_REGS),
   .PC_STEP   (PC_STEP),
   .ALIGN_LSB (ALIGN_LSB)
) u_chk (.*);

// File: tb/cpu_regfile_tb.sv
`timescale 1ns/1ps
module cpu_regfile_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0;
   logic [1:0]  rd_a_mode = '0, rd_b_mode = '0;
   logic [15:0] rd_a_data, rd_b_data, pc_out, sr_out;
   logic        wr_en = 1'b0, pc_inc = 1'b0, flag_we = 1'b0;
   logic [15:0] wr_data = '0, flag_mask = '0, flag_val = '0;

   always #2.5 clk = ~clk;

   cpu_regfile u_dut (.*);

   int    n_cmp = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur_tag = "R1";
   logic [15:0] m [16];

   initial for (int k = 0; k < 16; k++) m[k] = '0;

   function automatic logic [15:0] exp_rd(input logic [3:0] i, input logic [1:0] md);
      if (i == 4'd3) begin
         case (md)
            2'b00: return 16'h0000;
            2'b01: return 16'h0001;
            2'b10: return 16'h0002;
            default: return 16'hFFFF;
         endcase
      end
      if (i == 4'd2) begin
         case (md)
            2'b00: return m[2];
            2'b01: return 16'h0000;
            2'b10: return 16'h0004;
            default: return 16'h0008;
         endcase
      end
      return m[i];
   endfunction

   // reference state update, same edge as the design
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) m[k] = '0;
      end else begin
         if (wr_en && wr_idx == 4'd0)      m[0] = wr_data & 16'hFFFE;
         else if (pc_inc)                  m[0] = (m[0] + 16'd2) & 16'hFFFE;
         if (wr_en && wr_idx == 4'd2)      m[2] = wr_data;
         else if (flag_we)                 m[2] = (m[2] & ~flag_mask) | (flag_val & flag_mask);
         if (wr_en && wr_idx == 4'd1)      m[1] = wr_data & 16'hFFFE;
         if (wr_en && wr_idx >= 4'd4)      m[wr_idx] = wr_data;
      end
   end

   task automatic cmp(input string what, input logic [15:0] got, input logic [15:0] exp);
      n_cmp++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s %s: got %h expected %h at %0t", cur_tag, what, got, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      cmp("port A", rd_a_data, exp_rd(rd_a_idx, rd_a_mode));
      cmp("port B", rd_b_data, exp_rd(rd_b_idx, rd_b_mode));
      cmp("pc_out", pc_out, m[0]);
      cmp("sr_out", sr_out, m[2]);
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected at most 20000", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   task automatic drive(input logic we, input logic [3:0] wi, input logic [15:0] wd,
                        input logic inc, input logic fwe, input logic [15:0] fm,
                        input logic [15:0] fv, input logic [3:0] ai, input logic [1:0] am,
                        input logic [3:0] bi, input logic [1:0] bm);
      wr_en = we; wr_idx = wi; wr_data = wd; pc_inc = inc;
      flag_we = fwe; flag_mask = fm; flag_val = fv;
      rd_a_idx = ai; rd_a_mode = am; rd_b_idx = bi; rd_b_mode = bm;
      @(posedge clk); #1;
   endtask

   task automatic rd(input logic [3:0] ai, input logic [1:0] am,
                     input logic [3:0] bi, input logic [1:0] bm);
      drive(0, 0, 0, 0, 0, 0, 0, ai, am, bi, bm);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: everything reads zero after reset
      cur_tag = "R1";
      for (int i = 0; i < 16; i++) rd(4'(i), 2'b00, 4'(15 - i), 2'b00);

      // R2: general entries store and return data
      cur_tag = "R2";
      for (int i = 4; i < 16; i++)
         drive(1, 4'(i), 16'(i * 16'h1111) ^ 16'hA5C3, 0, 0, 0, 0, 4'(i), 2'b00, 4'(i), 2'b00);
      for (int i = 4; i < 16; i++) rd(4'(i), 2'b00, 4'(19 - i), 2'b00);

      // R6: mode code ignored on ordinary entries
      cur_tag = "R6";
      for (int i = 4; i < 16; i++)
         for (int md = 0; md < 4; md++) rd(4'(i), 2'(md), 4'(i), 2'(3 - md));

      // R3: constant source values per mode
      cur_tag = "R3";
      for (int md = 0; md < 4; md++) rd(4'd3, 2'(md), 4'd3, 2'(3 - md));

      // R4: write to entry 3 is dropped, other entries untouched
      cur_tag = "R4";
      drive(1, 4'd3, 16'hFFFF, 0, 0, 0, 0, 4'd3, 2'b00, 4'd4, 2'b00);
      for (int md = 0; md < 4; md++) rd(4'd3, 2'(md), 4'd2, 2'b00);
      rd(4'd0, 2'b00, 4'd1, 2'b00);

      // R5: status entry constants
      cur_tag = "R5";
      drive(1, 4'd2, 16'h5A5B, 0, 0, 0, 0, 4'd2, 2'b00, 4'd2, 2'b01);
      for (int md = 0; md < 4; md++) rd(4'd2, 2'(md), 4'd2, 2'(3 - md));

      // R7: direct writes to pointer and status entries
      cur_tag = "R7";
      drive(1, 4'd0, 16'h1235, 0, 0, 0, 0, 4'd0, 2'b00, 4'd1, 2'b00);
      drive(1, 4'd1, 16'hBEEF, 0, 0, 0, 0, 4'd0, 2'b11, 4'd1, 2'b10);
      drive(1, 4'd2, 16'h0001, 0, 0, 0, 0, 4'd1, 2'b01, 4'd2, 2'b00);
      rd(4'd2, 2'b00, 4'd1, 2'b00);

      // R8: counter advance, wrap, and write priority
      cur_tag = "R8";
      repeat (3) drive(0, 0, 0, 1, 0, 0, 0, 4'd0, 2'b00, 4'd0, 2'b01);
      drive(1, 4'd0, 16'hFFFE, 0, 0, 0, 0, 4'd0, 2'b00, 4'd0, 2'b00);
      drive(0, 0, 0, 1, 0, 0, 0, 4'd0, 2'b00, 4'd0, 2'b00);
      drive(1, 4'd0, 16'h4001, 1, 0, 0, 0, 4'd0, 2'b00, 4'd0, 2'b00);
      rd(4'd0, 2'b00, 4'd0, 2'b10);

      // R9: masked flag update and write priority
      cur_tag = "R9";
      drive(0, 0, 0, 0, 1, 16'h00FF, 16'h1234, 4'd2, 2'b00, 4'd2, 2'b00);
      drive(0, 0, 0, 0, 1, 16'hF000, 16'hFFFF, 4'd2, 2'b00, 4'd2, 2'b00);
      drive(1, 4'd2, 16'h0F0F, 0, 1, 16'hFFFF, 16'hFFFF, 4'd2, 2'b00, 4'd2, 2'b00);
      drive(0, 0, 0, 0, 1, 16'h0000, 16'hFFFF, 4'd2, 2'b00, 4'd2, 2'b00);
      rd(4'd2, 2'b00, 4'd2, 2'b00);

      // R10: mixed traffic on both ports with all update sources
      cur_tag = "R10";
      for (int n = 0; n < 600; n++) begin
         logic [31:0] r1v, r2v;
         r1v = $urandom;
         r2v = $urandom;
         drive(r1v[0], r1v[4:1], r2v[15:0], r1v[5], r1v[6], r2v[31:16], r1v[31:16],
               r1v[10:7], r1v[12:11], r1v[14:13] == 2'b00 ? 4'd2 : r2v[3:0], r1v[16:15]);
      end

      rd(4'd0, 2'b00, 4'd3, 2'b00);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule